// File: doc/BRIEF.md
# Nibble-Serial Debug Memory Access Port

This block gives an external debug host a four-wire data path into target memory. The host raises a frame strobe and presents one nibble per clock. The first nibble is a spare nibble, the second is a command, the next eight carry a 32-bit address, and a write also carries its data. Once the frame is complete, the block starts exactly one transfer on a simple internal bus master interface. It then reports progress on its four output lines, which the host polls.

The output reads 0000 while the transfer is outstanding. When the transfer ends, the output shows a ready code whose upper bits flag a malformed command or a failed transfer. For a successful read, the host drops the strobe after it sees the ready code, and the block then plays the fetched data back one nibble per clock, least significant nibble first.

The port only responds after its own port reset has been released while the mode select input was high. In any other state it stays silent.

Top module: `nib_dbg_port`

## Requirements
- R1: The port is enabled only if `mode_sel` is high in the last cycle that `port_rst_n` is low. When the port is disabled, frames are ignored: `bus_req` stays 0 and `nib_o` stays 0000.
- R2: A frame is counted in nibbles sampled on rising edges while `sync_i` is high. Nibble 0 is a spare and its value is ignored. Nibble 1 is the command. Nibbles 2 to 9 form `bus_addr`, least significant nibble first (nibble 2 goes to bits 3:0, nibble 9 to bits 31:28), and the address is passed to the bus unchanged.
- R3: Command bit 2 selects write (1) or read (0), and this value drives `bus_we`. Bits 1:0 select the size (00 byte, 01 word, 10 longword) and drive `bus_size`. A write frame carries 2, 4 or 8 data nibbles after the address, least significant first, and they appear on `bus_wdata` with all unused upper bits at zero.
- R4: One clock after the last nibble of a legal frame, `bus_req` rises. It holds with stable address, size and direction until a cycle in which `bus_done` is high. Each frame produces exactly one request.
- R5: While a request is outstanding, `nib_o` reads 0000 (not ready).
- R6: In the cycle after `bus_done`, `nib_o` presents the ready code. Bit 0 is 1, bit 1 is 0, bit 3 is 0, and bit 2 equals the `bus_err` value sampled with `bus_done`. The code holds while `sync_i` stays high.
- R7: A command is illegal when its bit 3 is 0 or its size is 11. An illegal command frame is 10 nibbles long. It issues no request and presents the ready code 0011 one clock after its last nibble.
- R8: After a successful read, once `sync_i` is sampled low during the ready code, `nib_o` shows the read data starting one clock later. It shows 2, 4 or 8 nibbles for byte, word or longword, least significant nibble first, and then returns to 0000.
- R9: If `sync_i` falls before a frame is complete, the partial frame is dropped, no request is made, and a new frame can start afterwards.
- R10: After a write, a command error or a bus error, dropping `sync_i` during the ready code returns `nib_o` to 0000 without any data nibbles.
- R11: While idle or receiving a frame, `nib_o` reads 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous chip reset, active low |
| port_rst_n | input | 1 | Debug port reset, active low; its release samples the mode select |
| mode_sel | input | 1 | Selects the memory access mode at port reset release |
| sync_i | input | 1 | Frame strobe from the host |
| nib_i | input | 4 | Nibble input from the host |
| nib_o | output | 4 | Status or read data nibble to the host |
| bus_req | output | 1 | Transfer request, held until done |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_size | output | 2 | 00 byte, 01 word, 10 longword |
| bus_addr | output | 32 | Transfer address |
| bus_wdata | output | 32 | Write data, zero-extended |
| bus_rdata | input | 32 | Read data, valid with bus_done |
| bus_done | input | 1 | Transfer completion |
| bus_err | input | 1 | Transfer failure, valid with bus_done |

## Verification
The assertions assume that the bus side raises `bus_done` only while `bus_req` is high, and that `port_rst_n` is not pulled during a transfer. The bench's bus responder answers only after it sees a request, after a random wait of zero to four cycles. It drives `bus_err` for unaligned word or longword addresses and for the top address region. The host side keeps `sync_i` high from the first nibble until the ready code has been read. It breaks that rule only in the deliberate truncation cases.

// File: rtl/nibdbg_pkg.sv
package nibdbg_pkg;

  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_EXEC = 2'd1,
    CS_STAT = 2'd2,
    CS_SEND = 2'd3
  } ctl_state_t;

  // legal command: top bit set and size field not the reserved code
  function automatic logic cmd_ok(input logic [3:0] c);
    return c[3] && (c[1:0] != 2'b11);
  endfunction

  // nibbles carried by an access of the given size code
  function automatic int size_nibs(input logic [1:0] s);
    return 2 << s;
  endfunction

  // ready status nibble
  function automatic logic [3:0] status_nib(input logic cmd_err, input logic bus_err);
    return {1'b0, bus_err, cmd_err, 1'b1};
  endfunction

endpackage

// File: rtl/nib_mode_gate.sv
module nib_mode_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic port_rst_n,
  input  logic mode_sel,
  output logic en
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      en    <= 1'b0;
    end else if (!port_rst_n) begin
      armed <= mode_sel;
      en    <= 1'b0;
    end else begin
      en <= armed;
    end
  end
endmodule

// File: rtl/nib_frame_rx.sv
module nib_frame_rx
  import nibdbg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              accept,
  input  logic              sync,
  input  logic [3:0]        nib,
  output logic              frame_last,
  output logic              abort,
  output logic [3:0]        cmd_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);
  localparam int ANIB  = ADDR_W / 4;
  localparam int DNIB  = DATA_W / 4;
  localparam int HDR   = 2 + ANIB;
  localparam int MAXF  = HDR + DNIB;
  localparam int CW    = $clog2(MAXF + 1);

  logic          active;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last_idx;

  function automatic int frame_nibs(input logic [3:0] c);
    return (cmd_ok(c) && c[2]) ? HDR + size_nibs(c[1:0]) : HDR;
  endfunction

  assign last_idx   = CW'(frame_nibs(cmd_q) - 1);
  assign frame_last = en && active && sync && (cnt == last_idx);
  assign abort      = en && active && !sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cnt     <= '0;
      cmd_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (!en) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (active) begin
      if (!sync) begin
        active <= 1'b0;
      end else begin
        if (cnt == CW'(1)) cmd_q <= nib;
        for (int k = 0; k < ANIB; k++)
          if (cnt == CW'(2 + k)) addr_q[4*k +: 4] <= nib;
        for (int k = 0; k < DNIB; k++)
          if (cnt == CW'(HDR + k)) wdata_q[4*k +: 4] <= nib;
        if (cnt == last_idx) active <= 1'b0;
        else                 cnt    <= cnt + CW'(1);
      end
    end else if (accept && sync) begin
      active  <= 1'b1;
      cnt     <= CW'(1);
      wdata_q <= '0;
    end
  end
endmodule

// File: rtl/nib_tx.sv
module nib_tx
  import nibdbg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] rdata,
  input  logic              load,
  input  logic              step,
  input  logic [1:0]        size,
  output logic [3:0]        nib,
  output logic              last
);
  localparam int DNIB = DATA_W / 4;
  localparam int IW   = $clog2(DNIB);

  logic [DATA_W-1:0] rdata_q;
  logic [IW-1:0]     idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      idx     <= '0;
    end else begin
      if (capture) rdata_q <= rdata;
      if (load)      idx <= '0;
      else if (step) idx <= idx + IW'(1);
    end
  end

  assign last = (int'(idx) == size_nibs(size) - 1);

  always_comb begin
    nib = 4'h0;
    for (int k = 0; k < DNIB; k++)
      if (idx == IW'(k)) nib = rdata_q[4*k +: 4];
  end
endmodule

// File: rtl/nib_ctl.sv
module nib_ctl
  import nibdbg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       frame_last,
  input  logic [3:0] cmd,
  input  logic       sync,
  input  logic       bus_done,
  input  logic       bus_err,
  input  logic       tx_last,
  output ctl_state_t state,
  output logic       cmd_err_q,
  output logic       bus_err_q,
  output logic       tx_load
);
  logic read_ok;

  assign read_ok = !cmd_err_q && !bus_err_q && !cmd[2];
  assign tx_load = (state == CS_STAT) && !sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= CS_IDLE;
      cmd_err_q <= 1'b0;
      bus_err_q <= 1'b0;
    end else if (!en) begin
      state <= CS_IDLE;
    end else begin
      unique case (state)
        CS_IDLE: if (frame_last) begin
          cmd_err_q <= !cmd_ok(cmd);
          bus_err_q <= 1'b0;
          state     <= cmd_ok(cmd) ? CS_EXEC : CS_STAT;
        end
        CS_EXEC: if (bus_done) begin
          bus_err_q <= bus_err;
          state     <= CS_STAT;
        end
        CS_STAT: if (!sync) state <= read_ok ? CS_SEND : CS_IDLE;
        CS_SEND: if (tx_last) state <= CS_IDLE;
        default: state <= CS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nib_dbg_port.sv
module nib_dbg_port
  import nibdbg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_rst_n,
  input  logic              mode_sel,
  input  logic              sync_i,
  input  logic [3:0]        nib_i,
  output logic [3:0]        nib_o,
  output logic              bus_req,
  output logic              bus_we,
  output logic [1:0]        bus_size,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_done,
  input  logic              bus_err
);
  logic       mon_en;
  logic       frame_last;
  logic       rx_abort;
  logic [3:0] cmd_q;
  ctl_state_t state;
  logic       cmd_err_q;
  logic       bus_err_q;
  logic       tx_load;
  logic       tx_last;
  logic [3:0] tx_nib;
  logic       access_end;

  nib_mode_gate u_gate (
    .clk(clk), .rst_n(rst_n), .port_rst_n(port_rst_n),
    .mode_sel(mode_sel), .en(mon_en)
  );

  nib_frame_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(mon_en), .accept(state == CS_IDLE),
    .sync(sync_i), .nib(nib_i), .frame_last(frame_last), .abort(rx_abort),
    .cmd_q(cmd_q), .addr_q(bus_addr), .wdata_q(bus_wdata)
  );

  nib_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .en(mon_en), .frame_last(frame_last),
    .cmd(cmd_q), .sync(sync_i), .bus_done(bus_done), .bus_err(bus_err),
    .tx_last(tx_last), .state(state), .cmd_err_q(cmd_err_q),
    .bus_err_q(bus_err_q), .tx_load(tx_load)
  );

  assign access_end = bus_req && bus_done;

  nib_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .capture(access_end), .rdata(bus_rdata),
    .load(tx_load), .step(state == CS_SEND), .size(cmd_q[1:0]),
    .nib(tx_nib), .last(tx_last)
  );

  assign bus_req  = mon_en && (state == CS_EXEC);
  assign bus_we   = cmd_q[2];
  assign bus_size = cmd_q[1:0];

  always_comb begin
    nib_o = 4'h0;
    if (mon_en) begin
      unique case (state)
        CS_STAT: nib_o = status_nib(cmd_err_q, bus_err_q);
        CS_SEND: nib_o = tx_nib;
        default: nib_o = 4'h0;
      endcase
    end
  end
endmodule

// File: rtl/nib_dbg_port_chk.sv
module nib_dbg_port_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              port_rst_n,
  input logic              mon_en,
  input logic              rx_abort,
  input logic              bus_req,
  input logic              bus_done,
  input logic              bus_err,
  input logic              bus_we,
  input logic [1:0]        bus_size,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        nib_o
);
  p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |-> (!bus_req && nib_o == 4'h0));

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n || !port_rst_n)
    (bus_req && !bus_done) |=> bus_req);

  p_req_stable_r4: assert property (@(posedge clk) disable iff (!rst_n || !port_rst_n)
    (bus_req && !bus_done) |=> ($stable(bus_addr) && $stable(bus_size) && $stable(bus_we)));

  p_size_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_size != 2'b11));

  p_not_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (nib_o == 4'h0));

  p_ready_code_r6: assert property (@(posedge clk) disable iff (!rst_n || !port_rst_n)
    (bus_req && bus_done) |=> (nib_o[0] && !nib_o[1] && !nib_o[3] && (nib_o[2] == $past(bus_err))));

  p_abort_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n || !port_rst_n)
    rx_abort |=> !bus_req);
endmodule

bind nib_dbg_port nib_dbg_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_rst_n(port_rst_n), .mon_en(mon_en),
  .rx_abort(rx_abort), .bus_req(bus_req), .bus_done(bus_done),
  .bus_err(bus_err), .bus_we(bus_we), .bus_size(bus_size),
  .bus_addr(bus_addr), .nib_o(nib_o)
);

// File: tb/sim_nib_dbg_port.sv
`timescale 1ns/1ps
module sim_nib_dbg_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        port_rst_n = 1'b0;
  logic        mode_sel = 1'b0;
  logic        sync_i = 1'b0;
  logic [3:0]  nib_i = 4'h0;
  logic [3:0]  nib_o;
  logic        bus_req, bus_we;
  logic [1:0]  bus_size;
  logic [31:0] bus_addr, bus_wdata;
  logic [31:0] bus_rdata = 32'h0;
  logic        bus_done = 1'b0;
  logic        bus_err = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit over   = 0;

  always #2 clk = ~clk;

  nib_dbg_port u0 (
    .clk(clk), .rst_n(rst_n), .port_rst_n(port_rst_n), .mode_sel(mode_sel),
    .sync_i(sync_i), .nib_i(nib_i), .nib_o(nib_o), .bus_req(bus_req),
    .bus_we(bus_we), .bus_size(bus_size), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_done(bus_done),
    .bus_err(bus_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!over) begin
      over = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  function automatic bit legal(input logic [3:0] c);
    return (c & 4'b1000) != 0 && c[1:0] < 2'd3;
  endfunction
  function automatic int dnibs(input logic [1:0] s);
    return s == 2'd0 ? 2 : (s == 2'd1 ? 4 : 8);
  endfunction
  function automatic logic [31:0] size_mask(input logic [1:0] s);
    return s == 2'd0 ? 32'hFF : (s == 2'd1 ? 32'hFFFF : 32'hFFFF_FFFF);
  endfunction
  function automatic bit exp_err(input logic [31:0] a, input logic [1:0] s);
    return (s == 2'd1 && a[0]) || (s == 2'd2 && a[1:0] != 2'b00) || a[31:28] == 4'hF;
  endfunction
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'hC3A5_5A3C;
  endfunction

  task automatic enable_port(input bit mode);
    @(negedge clk);
    port_rst_n = 1'b0; mode_sel = mode;
    repeat (2) @(negedge clk);
    port_rst_n = 1'b1;
    @(negedge clk);
    mode_sel = $urandom_range(0, 1);
    repeat (2) @(negedge clk);
  endtask

  // send the first n nibbles of a frame; n < 0 means the whole frame
  task automatic send(input logic [3:0] cmd, input logic [31:0] a, input logic [31:0] d,
                      input int n, output int len);
    logic [3:0] f [0:17];
    f[0] = 4'h0; f[1] = cmd;
    for (int k = 0; k < 8; k++) f[2+k] = a[4*k +: 4];
    for (int k = 0; k < 8; k++) f[10+k] = d[4*k +: 4];
    len = 10 + ((legal(cmd) && cmd[2]) ? dnibs(cmd[1:0]) : 0);
    for (int i = 0; i < ((n < 0) ? len : n); i++) begin
      @(negedge clk);
      sync_i = 1'b1;
      nib_i = (i == 0) ? 4'($urandom) : f[i];
    end
  endtask

  task automatic frame(input logic [3:0] cmd, input logic [31:0] a, input logic [31:0] d, input int wt);
    int len;
    bit err;
    logic [31:0] rd;
    send(cmd, a, d, -1, len);
    @(negedge clk);
    nib_i = 4'($urandom);
    if (!legal(cmd)) begin
      chk(nib_o == 4'b0011, "R7 cmd error code", 32'(nib_o), 32'h3);
      chk(bus_req == 1'b0, "R7 no access", 32'(bus_req), 32'h0);
      sync_i = 1'b0;
      @(negedge clk);
      chk(nib_o == 4'h0 && !bus_req, "R10 after cmd error", 32'(nib_o), 32'h0);
      return;
    end
    err = exp_err(a, cmd[1:0]);
    rd  = mem_word(a);
    chk(bus_req == 1'b1, "R4 request", 32'(bus_req), 32'h1);
    chk(bus_addr == a, "R2 address", bus_addr, a);
    chk(bus_we == cmd[2] && bus_size == cmd[1:0], "R3 we/size", {bus_we, bus_size}, 32'(cmd[2:0]));
    if (cmd[2]) chk(bus_wdata == (d & size_mask(cmd[1:0])), "R3 wdata", bus_wdata, d & size_mask(cmd[1:0]));
    chk(nib_o == 4'h0, "R5 not ready", 32'(nib_o), 32'h0);
    for (int w = 0; w < wt; w++) begin
      @(negedge clk);
      chk(bus_req && nib_o == 4'h0, "R5 hold busy", {bus_req, nib_o}, 32'h10);
    end
    bus_done = 1'b1; bus_err = err; bus_rdata = rd;
    @(negedge clk);
    bus_done = 1'b0; bus_err = 1'b0; bus_rdata = 32'($urandom);
    chk(bus_req == 1'b0, "R4 single access", 32'(bus_req), 32'h0);
    chk(nib_o == {1'b0, err, 2'b01}, "R6 ready code", 32'(nib_o), 32'({1'b0, err, 2'b01}));
    @(negedge clk);
    chk(nib_o == {1'b0, err, 2'b01}, "R6 code holds", 32'(nib_o), 32'({1'b0, err, 2'b01}));
    sync_i = 1'b0;
    if (!cmd[2] && !err) begin
      for (int k = 0; k < dnibs(cmd[1:0]); k++) begin
        @(negedge clk);
        chk(nib_o == rd[4*k +: 4], "R8 read nibble", 32'(nib_o), 32'(rd[4*k +: 4]));
      end
      @(negedge clk);
      chk(nib_o == 4'h0, "R8 end of data", 32'(nib_o), 32'h0);
    end else begin
      @(negedge clk);
      chk(nib_o == 4'h0, "R10 no data", 32'(nib_o), 32'h0);
    end
  endtask

  task automatic truncated(input logic [3:0] cmd, input int n);
    int len;
    send(cmd, 32'h1234_5678, 32'hA5A5_5A5A, n, len);
    @(negedge clk);
    sync_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!bus_req && nib_o == 4'h0, "R9 partial frame dropped", {bus_req, nib_o}, 32'h0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!over) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      finish_run();
    end
  end

  initial begin
    int unsigned s;
    s = $urandom(32'd90210);
    repeat (3) @(negedge clk);
    chk(nib_o == 4'h0 && !bus_req, "R11 reset state", {bus_req, nib_o}, 32'h0);
    rst_n = 1'b1;

    // R1: port released with mode low stays silent
    enable_port(1'b0);
    begin
      int len;
      send(4'b1010, 32'h0000_1000, 32'h0, -1, len);
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        chk(!bus_req && nib_o == 4'h0, "R1 disabled port quiet", {bus_req, nib_o}, 32'h0);
      end
      sync_i = 1'b0;
    end
    enable_port(1'b1);
    chk(nib_o == 4'h0, "R11 idle output", 32'(nib_o), 32'h0);

    // directed
    frame(4'b1100, 32'h0000_2003, 32'h0000_00C7, 0);
    frame(4'b1101, 32'h0010_0002, 32'h0000_BEEF, 2);
    frame(4'b1110, 32'h2345_6788, 32'hDEAD_BEEF, 3);
    frame(4'b1000, 32'h0000_0041, 32'h0, 1);
    frame(4'b1001, 32'h0000_0046, 32'h0, 0);
    frame(4'b1010, 32'h8765_4320, 32'h0, 4);
    frame(4'b1001, 32'h0000_0047, 32'h0, 1);
    frame(4'b1110, 32'h0000_0102, 32'h1111_2222, 0);
    frame(4'b1010, 32'hF000_0000, 32'h0, 2);
    frame(4'b0100, 32'h0000_0010, 32'h0, 0);
    frame(4'b1011, 32'h0000_0010, 32'h0, 0);
    truncated(4'b1010, 1);
    truncated(4'b1110, 17);
    truncated(4'b1100, 9);
    frame(4'b1000, 32'h0000_0301, 32'h0, 1);

    // random
    for (int it = 0; it < 60; it++) begin
      logic [3:0]  c;
      logic [31:0] a;
      c = {1'b1, 1'($urandom), 2'($urandom_range(0, 2))};
      if ($urandom_range(0, 9) == 0) c = 4'($urandom);
      a = $urandom;
      if ($urandom_range(0, 1) == 1) a[1:0] = 2'b00;
      frame(c, a, $urandom, $urandom_range(0, 4));
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
    finish_run();
  end
endmodule